// File: doc/BRIEF.md
# Single-Transfer Bus Master Controller

This block lets local logic perform exactly one read or one write on a shared, pipelined, arbitrated bus of the AHB style. A one-cycle command pulse loads the address, the direction and the write data. The block then raises its bus request and waits until it sees grant and ready high together on a clock edge. At that edge it drops the request. In the following cycle it drives a NONSEQ address phase with burst type SINGLE. The data phase comes after the address phase. A one-cycle done pulse marks its end, and read data is returned with the pulse.

An arbiter that registers the request can only remove the grant a couple of cycles after the request falls. This means the master stays granted after its single transfer has been issued. In those cycles, and in every other cycle in which it has no real transfer, the block drives the IDLE transfer type. If the grant is withdrawn before the block has seen grant and ready together, the request stays up and the block tries again when the grant comes back. New commands are refused while a transfer is in progress.

Top module: `sbm_single_master`

## Requirements
- R1: After reset, bus_req, busy and done are low and bus_trans is IDLE (2'b00).
- R2: A cmd_valid pulse sampled while busy is low causes bus_req to be high in the next cycle.
- R3: bus_req stays high in every cycle that follows an edge on which grant and ready were not both high. This includes the cases where the grant was present without ready, and where the grant was withdrawn.
- R4: In the cycle after an edge on which bus_req, bus_grant and bus_ready were all high, bus_req is low and the address phase is driven. That phase has bus_trans NONSEQ (2'b10), bus_burst SINGLE (3'b000), the command's address and direction, and bus_size equal to log2 of the data width in bytes (2 for 32 bits).
- R5: The NONSEQ address phase, including its address, is held until an edge with bus_ready high accepts it.
- R6: bus_trans is IDLE (2'b00) in every cycle that is not the address phase. This includes the cycles in which the block is still granted after its transfer.
- R7: For a write, bus_wdata carries the command's data from the cycle after the address phase is accepted. It is held until an edge with bus_ready high ends the data phase.
- R8: done is high for exactly one cycle, the cycle after the data phase ends with bus_ready high. For a read, rd_data holds the bus_rdata value sampled at that edge.
- R9: busy is high from the cycle after the command is taken until done pulses, and it is low in the done cycle. A cmd_valid pulse while busy is high starts no transfer and changes nothing on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_wdata | input | DATA_W | Write data |
| busy | output | 1 | Transfer in progress; commands refused |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read result, valid with done |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Grant from the arbiter |
| bus_ready | input | 1 | Bus ready, shared |
| bus_trans | output | 2 | Transfer type: 00 IDLE, 10 NONSEQ |
| bus_burst | output | 3 | Burst type, always SINGLE 000 |
| bus_size | output | 3 | Transfer size code |
| bus_write | output | 1 | Direction of the address phase |
| bus_addr | output | ADDR_W | Address |
| bus_wdata | output | DATA_W | Write data in the data phase |
| bus_rdata | input | DATA_W | Read data from the slave |

## Verification
Suppose the phase register left the request phase too early, or stayed in it too long. The fault would show at the ports within one cycle of the grant edge: either bus_req would fall while no NONSEQ appears, or bus_req would stay high beside a NONSEQ. A phase that stuck in the address or data state would show as a NONSEQ that never clears, or as a missing done pulse. Either would be seen one cycle after the ready edge that should have moved it on. A command register that is reloaded while busy would show as a changed address, or as a second transfer for which the scoreboard holds no entry. A request that was not kept up after a lost grant would show as bus_req low in the next cycle.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ADDR = 2'd2,
    ST_DATA = 2'd3
  } phase_e;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [2:0] BURST_SINGLE = 3'b000;

  // size code: log2 of the bus width in bytes
  function automatic logic [2:0] size_code(input int unsigned width_bits);
    int unsigned bytes;
    bytes = width_bits / 8;
    return 3'($clog2(bytes));
  endfunction

  // ownership of the next address phase is won on an edge with both high
  function automatic logic wins_bus(input logic req, input logic grant, input logic ready);
    return req & grant & ready;
  endfunction
endpackage

// File: rtl/sbm_phase_fsm.sv
module sbm_phase_fsm
  import sbm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_valid,
  input  logic   bus_grant,
  input  logic   bus_ready,
  output phase_e phase,
  output logic   take_cmd,
  output logic   issue_evt,
  output logic   accept_evt,
  output logic   finish_evt
);
  phase_e phase_q;
  logic   req_now;

  assign req_now    = (phase_q == ST_REQ);
  assign take_cmd   = (phase_q == ST_IDLE) && cmd_valid;
  assign issue_evt  = wins_bus(req_now, bus_grant, bus_ready);
  assign accept_evt = (phase_q == ST_ADDR) && bus_ready;
  assign finish_evt = (phase_q == ST_DATA) && bus_ready;
  assign phase      = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
    end else begin
      unique case (phase_q)
        ST_IDLE: if (take_cmd)   phase_q <= ST_REQ;
        ST_REQ:  if (issue_evt)  phase_q <= ST_ADDR;
        ST_ADDR: if (accept_evt) phase_q <= ST_DATA;
        ST_DATA: if (finish_evt) phase_q <= ST_IDLE;
        default: phase_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbm_addr_regs.sv
module sbm_addr_regs
  import sbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_cmd,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  phase_e            phase,
  output logic              write_q,
  output logic [1:0]        bus_trans,
  output logic [2:0]        bus_burst,
  output logic [2:0]        bus_size,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr
);
  localparam logic [2:0] SIZE_CODE = size_code(DATA_W);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
    end else if (take_cmd) begin
      addr_q  <= cmd_addr;
      write_q <= cmd_write;
    end
  end

  // the only real transfer type is the single address phase; all else is IDLE
  assign bus_trans = (phase == ST_ADDR) ? TRANS_NONSEQ : TRANS_IDLE;
  assign bus_burst = BURST_SINGLE;
  assign bus_size  = SIZE_CODE;
  assign bus_write = write_q;
  assign bus_addr  = addr_q;
endmodule

// File: rtl/sbm_data_path.sv
module sbm_data_path
  import sbm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_cmd,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              write_q,
  input  phase_e            phase,
  input  logic              finish_evt,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_evt;
      if (take_cmd) wdata_q <= cmd_wdata;
      if (finish_evt && !write_q) rdata_q <= bus_rdata;
    end
  end

  assign bus_wdata = ((phase == ST_DATA) && write_q) ? wdata_q : '0;
  assign rd_data   = rdata_q;
  assign done      = done_q;
endmodule

// File: rtl/sbm_single_master.sv
module sbm_single_master
  import sbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              bus_ready,
  output logic [1:0]        bus_trans,
  output logic [2:0]        bus_burst,
  output logic [2:0]        bus_size,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  phase_e phase;
  logic   take_cmd;
  logic   issue_evt;
  logic   accept_evt;
  logic   finish_evt;
  logic   write_q;
  logic   data_phase;

  sbm_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .bus_grant  (bus_grant),
    .bus_ready  (bus_ready),
    .phase      (phase),
    .take_cmd   (take_cmd),
    .issue_evt  (issue_evt),
    .accept_evt (accept_evt),
    .finish_evt (finish_evt)
  );

  sbm_addr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_cmd  (take_cmd),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .phase     (phase),
    .write_q   (write_q),
    .bus_trans (bus_trans),
    .bus_burst (bus_burst),
    .bus_size  (bus_size),
    .bus_write (bus_write),
    .bus_addr  (bus_addr)
  );

  sbm_data_path #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_cmd   (take_cmd),
    .cmd_wdata  (cmd_wdata),
    .write_q    (write_q),
    .phase      (phase),
    .finish_evt (finish_evt),
    .bus_rdata  (bus_rdata),
    .bus_wdata  (bus_wdata),
    .rd_data    (rd_data),
    .done       (done)
  );

  assign bus_req    = (phase == ST_REQ);
  assign busy       = (phase != ST_IDLE);
  assign data_phase = (phase == ST_DATA);
endmodule

// File: rtl/sbm_single_master_chk.sv
module sbm_single_master_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          bus_ready,
  input logic [1:0]    bus_trans,
  input logic [2:0]    bus_burst,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          busy,
  input logic          done,
  input logic          data_phase,
  input logic          issue_evt,
  input logic          accept_evt
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !(bus_grant && bus_ready) |=> bus_req);

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |=> !bus_req && bus_trans == 2'b10);

  // R4
  single_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trans == 2'b10 |-> bus_burst == 3'b000);

  // R5
  nonseq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trans == 2'b10 && !bus_ready |=> bus_trans == 2'b10 && $stable(bus_addr));

  // R6
  idle_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> bus_trans == 2'b00 && data_phase);

  // R7
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase && !bus_ready |=> $stable(bus_wdata));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bus_addr));

  // R9
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind sbm_single_master sbm_single_master_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_grant  (bus_grant),
  .bus_ready  (bus_ready),
  .bus_trans  (bus_trans),
  .bus_burst  (bus_burst),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .busy       (busy),
  .done       (done),
  .data_phase (data_phase),
  .issue_evt  (issue_evt),
  .accept_evt (accept_evt)
);

// File: tb/sbm_single_master_bench.sv
module sbm_single_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        busy, done, bus_req, bus_write;
  logic [31:0] rd_data, bus_addr, bus_wdata;
  logic        bus_grant = 1'b0;
  logic        bus_ready = 1'b1;
  logic [1:0]  bus_trans;
  logic [2:0]  bus_burst, bus_size;
  logic [31:0] rd_drive = '0;

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic        w;
    logic [31:0] a;
    logic [31:0] d;
  } item_t;

  item_t exp_q[$];
  item_t cur;
  bit    in_data = 0;
  bit    pend_done = 0;
  bit    wait_ns = 0;

  always #4 clk = ~clk;

  sbm_single_master u_sbm_single_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_ready(bus_ready), .bus_trans(bus_trans), .bus_burst(bus_burst),
    .bus_size(bus_size), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_drive)
  );

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_0F96;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // monitor: compares bus activity with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_done) begin
        chk(done === 1'b1, "R8 done pulse", done, 1);
        chk(busy === 1'b0, "R9 busy low with done", busy, 0);
        if (!cur.w) chk(rd_data === rd_pat(cur.a), "R8 read data", rd_data, rd_pat(cur.a));
        pend_done = 0;
      end else begin
        chk(done === 1'b0, "R8 no stray done", done, 0);
      end
      if (wait_ns) chk(bus_trans === 2'b10, "R5 address phase held", bus_trans, 2'b10);
      wait_ns = 0;
      if (in_data) begin
        chk(bus_trans === 2'b00, "R6 idle during data phase", bus_trans, 2'b00);
        if (cur.w) chk(bus_wdata === cur.d, "R7 write data", bus_wdata, cur.d);
        if (bus_ready) begin
          in_data = 0;
          pend_done = 1;
        end
      end else if (bus_trans === 2'b10) begin
        chk(bus_burst === 3'b000, "R4 burst SINGLE", bus_burst, 0);
        chk(bus_size === 3'd2, "R4 size code", bus_size, 2);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 transfer with no command", bus_addr, 0);
        end else begin
          chk(bus_addr === exp_q[0].a, "R4 address", bus_addr, exp_q[0].a);
          chk(bus_write === exp_q[0].w, "R4 direction", bus_write, exp_q[0].w);
          if (bus_ready) begin
            cur = exp_q.pop_front();
            rd_drive = rd_pat(cur.a);
            in_data = 1;
          end else begin
            wait_ns = 1;
          end
        end
      end else begin
        chk(bus_trans === 2'b00, "R6 idle type", bus_trans, 2'b00);
      end
    end
  end

  // driver: one command through its full handshake
  task automatic xfer(input bit w, input logic [31:0] a, input logic [31:0] d,
                      input int gdelay, input bit flicker, input int aw, input int dw,
                      input bit poke);
    exp_q.push_back('{w: w, a: a, d: d});
    cmd_valid = 1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    cyc();
    cmd_valid = 0; cmd_addr = ~a; cmd_wdata = ~d; cmd_write = ~w;
    bus_grant = 0; bus_ready = 1;
    @(negedge clk);
    chk(bus_req === 1'b1, "R2 request raised", bus_req, 1);
    chk(busy === 1'b1, "R9 busy after command", busy, 1);
    for (int i = 0; i < gdelay; i++) begin
      cyc();
      bus_grant = 0;
      cmd_valid = poke && (i == 0);
      cmd_addr  = a + 32'h100;
      @(negedge clk);
      chk(bus_req === 1'b1, "R3 request kept without grant", bus_req, 1);
      chk(bus_addr === a, "R9 address kept while busy", bus_addr, a);
    end
    cmd_valid = 0;
    if (flicker) begin
      cyc(); bus_grant = 1; bus_ready = 0;
      @(negedge clk);
      chk(bus_req === 1'b1, "R3 request kept, grant without ready", bus_req, 1);
      cyc(); bus_grant = 0; bus_ready = 1;
      @(negedge clk);
      chk(bus_req === 1'b1, "R3 request kept after grant lost", bus_req, 1);
    end
    cyc(); bus_grant = 1; bus_ready = 1;
    cyc();
    bus_ready = (aw == 0);
    @(negedge clk);
    chk(bus_req === 1'b0, "R4 request dropped after grant", bus_req, 0);
    for (int i = 1; i <= aw; i++) begin cyc(); bus_ready = (i == aw); end
    cyc();
    bus_ready = (dw == 0);
    for (int i = 1; i <= dw; i++) begin cyc(); bus_ready = (i == dw); end
    cyc();
    bus_ready = 1;
    cyc();
    cyc();
    bus_grant = 0;
    @(negedge clk);
    chk(busy === 1'b0, "R9 idle after transfer", busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_req === 1'b0, "R1 reset request", bus_req, 0);
    chk(busy === 1'b0, "R1 reset busy", busy, 0);
    chk(bus_trans === 2'b00, "R1 reset transfer type", bus_trans, 0);
    chk(done === 1'b0, "R1 reset done", done, 0);
    cyc(); rst_n = 1;
    bus_grant = 1;
    repeat (3) cyc();
    bus_grant = 0;
    cyc();
    xfer(1'b1, 32'h0000_1000, 32'hDEAD_BEEF, 0, 1'b0, 0, 0, 1'b0);
    xfer(1'b0, 32'h0000_2004, 32'h0,         2, 1'b0, 1, 2, 1'b0);
    xfer(1'b1, 32'h0000_3008, 32'h1234_5678, 1, 1'b1, 2, 1, 1'b1);
    xfer(1'b0, 32'h0000_400C, 32'h0,         0, 1'b0, 0, 0, 1'b0);
    xfer(1'b1, 32'hFFFF_FFFC, 32'hA5A5_5A5A, 3, 1'b1, 0, 3, 1'b1);
    repeat (4) cyc();
    chk(exp_q.size() == 0, "R4 all commands issued", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule